// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block sits beside a byte-wide memory and watches its bus cycles. A host opens a side channel to a serial transfer engine by doing two things. First it issues one read to the device. Then it issues 64 consecutive writes whose data bit 0 spells out a fixed 64-bit key. Each bus cycle reaches the block as a single-clock strobe, together with a select flag, a write flag and the level of data bit 0.

Until the key has been fully recognised, every access goes to the memory as usual. When the last key bit matches, the block pulses an unlock flag for one clock. It then raises a memory-inhibit level, which hands the following cycles to the transfer engine. The engine ends its phase with a done pulse, and that pulse returns the recognizer to its disarmed idle state.

A read cycle is both the arming event and the abort event. A single wrong bit locks the recognizer out until the next read. The key length, the key value and the bit order are parameters.

Top module: `unlock_recognizer`

## Requirements
- R1: After reset the recognizer is disarmed, `unlock_pulse` is 0 and `mem_inhibit` is 0.
- R2: The default key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C. Each byte is sent least significant bit first on `cyc_d0`, one bit per selected write, starting with bit 0 of byte C5. After one selected read, 64 matching selected writes assert `unlock_pulse` at the clock edge that samples the 64th write strobe. `mem_inhibit` rises at that same edge, and it stays 0 after only 63 matching writes.
- R3: A selected read while the recognizer is armed resets the comparison pointer to bit 0 and aborts the recognition in progress. Sending only the remaining key bits after such a read does not unlock, while a full key from bit 0 does.
- R4: A selected write whose bit 0 differs from the key bit at the pointer locks the recognizer. All later writes are ignored until the next selected read, so neither the remaining bits nor a complete key written afterwards causes an unlock.
- R5: Strobes with `cyc_sel` low, whether reads or writes and whatever their data, do not move the pointer and do not abort or lock the recognition.
- R6: Selected writes that arrive before any selected read has armed the recognizer are ignored, so a complete key sent without a preceding read does not unlock.
- R7: `mem_inhibit` stays high for as long as the transfer phase runs, and selected reads and writes during that phase do not change it. A `xfer_done` pulse during the phase drops `mem_inhibit` one clock later and leaves the recognizer disarmed.
- R8: A `xfer_done` pulse outside the transfer phase has no effect on a recognition in progress.
- R9: `unlock_pulse` is high for exactly one clock per unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock strobe marking a bus cycle |
| cyc_sel | input | 1 | The cycle selects this device |
| cyc_we | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_d0 | input | 1 | Data bit 0 of the cycle |
| xfer_done | input | 1 | Pulse from the transfer engine ending its phase |
| unlock_pulse | output | 1 | One-clock flag on recognition of the full key |
| mem_inhibit | output | 1 | High while the transfer phase owns the bus |

## Verification
Some rules are checked by the assertions on every clock. A selected read outside the transfer phase always leaves the pointer at zero. An unselected strobe never moves the pointer. `mem_inhibit` only rises on a write strobe and only falls after `xfer_done`, and the unlock pulse is a single clock inside the transfer phase.

Other behaviour can only be shown by the bench's scenarios. These are the exact key value and its bit order, the lockout after a mismatch, the refusal of writes before arming, the abort on a mid-sequence read, and the harmlessness of a stray done pulse. Each of these needs a whole sequence of cycles whose outcome is judged at the end.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_LOCKED = 2'd2,
      ST_XFER   = 2'd3
   } rec_state_t;

   // Byte 0 sits in the low eight bits; LSB-first delivery walks upward.
   localparam logic [63:0] DEF_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

endpackage

// File: rtl/unlock_ptr.sv
module unlock_ptr #(
   parameter int KEY_LEN = 64,
   localparam int PTR_W = $clog2(KEY_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr,
   output logic             last
);

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(KEY_LEN - 1);

   assign last = (ptr == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= last ? '0 : ptr + 1'b1;
      end
   end

endmodule

// File: rtl/unlock_key_src.sv
module unlock_key_src #(
   parameter int              KEY_LEN   = 64,
   parameter logic [KEY_LEN-1:0] KEY    = '0,
   parameter bit              LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic adv,
   output logic key_bit
);

   logic [KEY_LEN-1:0] sr_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign key_bit = sr_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr_q <= KEY;
            else if (reload) sr_q <= KEY;
            else if (adv)    sr_q <= {sr_q[0], sr_q[KEY_LEN-1:1]};
         end
      end else begin : g_msb
         assign key_bit = sr_q[KEY_LEN-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr_q <= KEY;
            else if (reload) sr_q <= KEY;
            else if (adv)    sr_q <= {sr_q[KEY_LEN-2:0], sr_q[KEY_LEN-1]};
         end
      end
   endgenerate

endmodule

// File: rtl/unlock_fsm.sv
module unlock_fsm
   import unlock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_ev,
   input  logic       wr_ev,
   input  logic       d0,
   input  logic       key_bit,
   input  logic       ptr_last,
   input  logic       done,
   output logic       clr,
   output logic       adv,
   output rec_state_t state,
   output logic       unlock_pulse
);

   rec_state_t state_d;
   logic       pulse_d;
   logic       hit;

   assign hit = wr_ev && (d0 == key_bit);

   always_comb begin
      state_d = state;
      clr     = 1'b0;
      adv     = 1'b0;
      pulse_d = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (rd_ev) begin
               state_d = ST_ARMED;
               clr     = 1'b1;
            end
         end
         ST_ARMED: begin
            if (rd_ev) begin
               clr = 1'b1;
            end else if (hit) begin
               adv = 1'b1;
               if (ptr_last) begin
                  state_d = ST_XFER;
                  pulse_d = 1'b1;
               end
            end else if (wr_ev) begin
               state_d = ST_LOCKED;
            end
         end
         ST_LOCKED: begin
            if (rd_ev) begin
               state_d = ST_ARMED;
               clr     = 1'b1;
            end
         end
         ST_XFER: begin
            if (done) begin
               state_d = ST_IDLE;
               clr     = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         unlock_pulse <= 1'b0;
      end else begin
         state        <= state_d;
         unlock_pulse <= pulse_d;
      end
   end

endmodule

// File: rtl/unlock_recognizer.sv
module unlock_recognizer
   import unlock_pkg::*;
#(
   parameter int                 KEY_LEN   = 64,
   parameter logic [KEY_LEN-1:0] KEY       = KEY_LEN'(DEF_KEY),
   parameter bit                 LSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   input  logic cyc_sel,
   input  logic cyc_we,
   input  logic cyc_d0,
   input  logic xfer_done,
   output logic unlock_pulse,
   output logic mem_inhibit
);

   localparam int PTR_W = $clog2(KEY_LEN);

   generate
      if (KEY_LEN < 2) begin : g_bad_len
         $error("unlock_recognizer: KEY_LEN must be at least 2");
      end
      if (KEY_LEN > 4096) begin : g_big_len
         $error("unlock_recognizer: KEY_LEN above 4096 is not supported");
      end
   endgenerate

   logic             rd_ev;
   logic             wr_ev;
   logic             clr;
   logic             adv;
   logic             key_bit;
   logic             ptr_last;
   logic [PTR_W-1:0] ptr_q;
   rec_state_t       state;

   assign rd_ev = cyc_stb && cyc_sel && !cyc_we;
   assign wr_ev = cyc_stb && cyc_sel &&  cyc_we;

   unlock_ptr #(.KEY_LEN(KEY_LEN)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .adv  (adv),
      .ptr  (ptr_q),
      .last (ptr_last)
   );

   unlock_key_src #(
      .KEY_LEN  (KEY_LEN),
      .KEY      (KEY),
      .LSB_FIRST(LSB_FIRST)
   ) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (clr),
      .adv    (adv),
      .key_bit(key_bit)
   );

   unlock_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_ev       (rd_ev),
      .wr_ev       (wr_ev),
      .d0          (cyc_d0),
      .key_bit     (key_bit),
      .ptr_last    (ptr_last),
      .done        (xfer_done),
      .clr         (clr),
      .adv         (adv),
      .state       (state),
      .unlock_pulse(unlock_pulse)
   );

   assign mem_inhibit = (state == ST_XFER);

endmodule

// File: rtl/unlock_recognizer_chk.sv
module unlock_recognizer_chk #(
   parameter int PTR_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_stb,
   input logic             cyc_sel,
   input logic             cyc_we,
   input logic             xfer_done,
   input logic             unlock_pulse,
   input logic             mem_inhibit,
   input logic [PTR_W-1:0] ptr
);

   AST_READ_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && cyc_sel && !cyc_we && !mem_inhibit) |=> (ptr == '0)); // R3

   AST_UNSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cyc_stb && cyc_sel) && !xfer_done) |=> $stable(ptr)); // R5

   AST_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_inhibit) |-> $past(cyc_stb && cyc_sel && cyc_we)); // R2

   AST_PULSE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_pulse |-> mem_inhibit); // R2

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_pulse |=> !unlock_pulse); // R9

   AST_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_inhibit) |-> $past(xfer_done)); // R7

   AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_inhibit && xfer_done) |=> !mem_inhibit); // R7

endmodule

bind unlock_recognizer unlock_recognizer_chk #(.PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_stb     (cyc_stb),
   .cyc_sel     (cyc_sel),
   .cyc_we      (cyc_we),
   .xfer_done   (xfer_done),
   .unlock_pulse(unlock_pulse),
   .mem_inhibit (mem_inhibit),
   .ptr         (ptr_q)
);

// File: tb/unlock_recognizer_bench.sv
module unlock_recognizer_bench;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_stb = 1'b0;
   logic cyc_sel = 1'b0;
   logic cyc_we = 1'b0;
   logic cyc_d0 = 1'b0;
   logic xfer_done = 1'b0;
   logic unlock_pulse;
   logic mem_inhibit;

   int n_checks = 0;
   int n_fail = 0;
   int pulse_count = 0;

   logic [7:0] key_bytes [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (unlock_pulse) pulse_count++;

   unlock_recognizer u_unlock_recognizer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_stb     (cyc_stb),
      .cyc_sel     (cyc_sel),
      .cyc_we      (cyc_we),
      .cyc_d0      (cyc_d0),
      .xfer_done   (xfer_done),
      .unlock_pulse(unlock_pulse),
      .mem_inhibit (mem_inhibit)
   );

   function automatic logic key_bit(input int i);
      return key_bytes[i / 8][i % 8];
   endfunction

   task automatic check(input logic ok, input string req, input logic act, input logic exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic expect_outs(input string req, input logic pulse_e, input logic inh_e);
      check(unlock_pulse == pulse_e, {req, " unlock_pulse"}, unlock_pulse, pulse_e);
      check(mem_inhibit == inh_e, {req, " mem_inhibit"}, mem_inhibit, inh_e);
   endtask

   // One bus cycle: strobe for one clock, outputs sampled at the following negedge.
   task automatic bus(input logic sel, input logic we, input logic d0);
      @(negedge clk);
      cyc_stb = 1'b1; cyc_sel = sel; cyc_we = we; cyc_d0 = d0;
      @(negedge clk);
      cyc_stb = 1'b0; cyc_sel = 1'b0; cyc_we = 1'b0; cyc_d0 = 1'b0;
   endtask

   task automatic send_bits(input int from, input int to);
      for (int i = from; i <= to; i++) bus(1'b1, 1'b1, key_bit(i));
   endtask

   task automatic pulse_done();
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      expect_outs("R1", 1'b0, 1'b0);
   endtask

   task automatic t_no_arm();
      send_bits(0, 63);
      expect_outs("R6", 1'b0, 1'b0);
   endtask

   task automatic t_basic();
      int c0;
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 62);
      expect_outs("R2 after 63 bits", 1'b0, 1'b0);
      c0 = pulse_count;
      send_bits(63, 63);
      expect_outs("R2 on 64th bit", 1'b1, 1'b1);
      @(negedge clk);
      expect_outs("R9 pulse one clock", 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      check(pulse_count - c0 == 1, "R9 pulse count", pulse_count - c0 == 1, 1'b1);
   endtask

   task automatic t_transfer();
      bus(1'b1, 1'b0, 1'b0);
      bus(1'b1, 1'b1, 1'b1);
      bus(1'b1, 1'b1, 1'b0);
      expect_outs("R7 held during transfer", 1'b0, 1'b1);
      pulse_done();
      expect_outs("R7 released by done", 1'b0, 1'b0);
      send_bits(0, 63);
      expect_outs("R7 disarmed after done", 1'b0, 1'b0);
   endtask

   task automatic t_read_abort();
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 19);
      bus(1'b1, 1'b0, 1'b0);
      send_bits(20, 63);
      expect_outs("R3 tail after abort", 1'b0, 1'b0);
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 30);
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 63);
      expect_outs("R3 full key after abort", 1'b1, 1'b1);
      pulse_done();
   endtask

   task automatic t_mismatch();
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 9);
      bus(1'b1, 1'b1, ~key_bit(10));
      send_bits(10, 63);
      expect_outs("R4 retry after mismatch", 1'b0, 1'b0);
      send_bits(0, 63);
      expect_outs("R4 full key while locked", 1'b0, 1'b0);
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 63);
      expect_outs("R4 read clears lockout", 1'b1, 1'b1);
      pulse_done();
   endtask

   task automatic t_unselected();
      bus(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 64; i++) begin
         bus(1'b1, 1'b1, key_bit(i));
         if (i % 8 == 3) bus(1'b0, 1'b0, 1'b0);
         if (i % 8 == 5) bus(1'b0, 1'b1, ~key_bit(i + 1));
      end
      expect_outs("R5 unselected cycles ignored", 1'b1, 1'b1);
      pulse_done();
   endtask

   task automatic t_stray_done();
      bus(1'b1, 1'b0, 1'b0);
      send_bits(0, 40);
      pulse_done();
      send_bits(41, 63);
      expect_outs("R8 stray done ignored", 1'b1, 1'b1);
      pulse_done();
      expect_outs("R8 release", 1'b0, 1'b0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_arm();
      t_basic();
      t_transfer();
      t_read_abort();
      t_mismatch();
      t_unselected();
      t_stray_done();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule